// File: doc/BRIEF.md
# Gated 16-bit timer/counter

This block is a 16-bit up-counter exposed as two byte registers, fed from one of three count sources: the instruction rate (system clock divided by four), the system clock itself, or an external clock taken from either a clock pin or a secondary oscillator input. A prescaler divides the chosen source by 1, 2, 4 or 8. The external path can be passed through a synchronizer or used directly, and the synchronized path stops counting while the sleep input is high.

A gate can make counting depend on one of four signals: a gate pin, a period-match pulse from a neighbouring timer, or either of two comparator outputs. The gate signal can be inverted. In toggle mode, each rising edge of the gate flips a flip-flop, so counting spans whole gate periods. In single-pulse mode, software arms the gate with a go bit. The gate then opens for exactly one pulse, after which the go bit clears itself and a gate event flag is raised. A rollover from all ones to zero sets a sticky overflow flag. Everything is reached through a byte-wide register port with a combinational read.

Top module: `gtmr16_top`

## Requirements
- R1: After reset, every register reads 0. The register addresses are: 0 counter low byte, 1 counter high byte, 2 control, 3 gate configuration, 4 flags.
- R2: The control register has run at bit 0 and the source code at bits 2:1. Code 00 advances the count source once every 4 system clocks. Code 01 advances it every system clock. Code 11 never advances it.
- R3: Control bits 4:3 hold the prescale code p. The counter increments once per 2^p advances of the selected source.
- R4: Source code 10 counts rising edges of the external clock pin when control bit 6 is 0, and of the secondary oscillator input when bit 6 is 1. A rising edge counts only if a falling edge has been seen since run was set.
- R5: Control bit 5 set to 1 bypasses the external synchronizer. While the sleep input is high, external edges are not counted on the synchronized path but are still counted on the bypass path.
- R6: While run is 0, the counter holds its value.
- R7: Flags bit 0 is set when the counter increments from 0xFFFF to 0x0000. It stays set until a write puts a 0 in that bit. Writing a 1 there has no effect.
- R8: In the gate register, bit 0 is gate enable and bits 7:6 select the source: 00 pin, 01 neighbour match, 10 comparator 1, 11 comparator 2. Bit 1 inverts the source. With the gate enabled, counting happens only while the qualified gate is 1. Bit 5 reads the qualified gate value.
- R9: Gate bit 2 (toggle) makes each rising edge of the inverted-or-not source flip the gate. The gate starts at 0 when toggle mode is entered.
- R10: With gate bit 3 (single pulse) set, writing 1 to gate bit 4 (go) arms the gate. Counting then happens only during the next complete gate pulse. When that pulse ends, go reads 0 and flags bit 1 is set. Flags bit 1 clears on a write of 0 to that bit.
- R11: A write to a counter byte loads that byte. A write to the low byte also restarts the prescaler, so with a prescale code of 3 the next increment comes exactly 8 source advances later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_i | input | 1 | External count clock pin |
| sosc_i | input | 1 | Secondary oscillator output |
| sleep_i | input | 1 | High while the chip sleeps |
| gate_pin_i | input | 1 | External gate pin |
| nbr_match_i | input | 1 | Period-match pulse from the neighbouring timer |
| cmp1_i | input | 1 | Comparator 1 output |
| cmp2_i | input | 1 | Comparator 2 output |
| reg_addr_i | input | 3 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| ovf_flag_o | output | 1 | Overflow flag |
| gate_flag_o | output | 1 | Single-pulse completion flag |

## Verification
The bench builds the block with its defaults: 8-bit bytes, two counter bytes and two synchronizer stages. With only four source codes and four prescale codes, it can sweep every combination of source and divider, including both external inputs with and without the synchronizer. It then sweeps every gate source against both polarities and both levels. Each result is a difference in the counter's low byte over a fixed window, which stays below 256, so the expected value is plain division.

// File: rtl/gtmr16_pkg.sv
package gtmr16_pkg;

   localparam int PSEL_W = 2;
   localparam int PRE_W  = 3;

   typedef enum logic [1:0] {
      SRC_INSTR = 2'b00,
      SRC_SYS   = 2'b01,
      SRC_EXT   = 2'b10,
      SRC_NONE  = 2'b11
   } cnt_src_e;

   typedef enum logic [1:0] {
      GSEL_PIN   = 2'b00,
      GSEL_MATCH = 2'b01,
      GSEL_CMP1  = 2'b10,
      GSEL_CMP2  = 2'b11
   } gate_sel_e;

   typedef enum logic [1:0] {
      SP_IDLE   = 2'b00,
      SP_WAIT   = 2'b01,
      SP_ACTIVE = 2'b10
   } sp_state_e;

endpackage

// File: rtl/gtmr16_sync.sv
module gtmr16_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] sh;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sh <= '0;
            else        sh <= d_i;
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-2:0], d_i};
      end
   endgenerate

   assign q_o = sh[STAGES-1];
endmodule

// File: rtl/gtmr16_clk_sel.sv
module gtmr16_clk_sel
   import gtmr16_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     run_i,
   input  cnt_src_e src_i,
   input  logic     bypass_i,
   input  logic     osc_sel_i,
   input  logic     ext_clk_i,
   input  logic     sosc_i,
   input  logic     sleep_i,
   output logic     tick_o
);
   logic [1:0] q4;
   logic ext_raw, ext_s, ext_v, ext_p, armed, ext_hit;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) q4 <= '0;
      else        q4 <= q4 + 2'd1;

   assign ext_raw = osc_sel_i ? sosc_i : ext_clk_i;

   gtmr16_sync #(.STAGES(SYNC_STAGES)) u_esync (
      .clk(clk), .rst_n(rst_n), .d_i(ext_raw), .q_o(ext_s)
   );

   assign ext_v = bypass_i ? ext_raw : ext_s;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         ext_p <= 1'b0;
         armed <= 1'b0;
      end else begin
         ext_p <= ext_v;
         if (!run_i || src_i != SRC_EXT) armed <= 1'b0;
         else if (!ext_v && ext_p)       armed <= 1'b1;
      end

   assign ext_hit = ext_v & ~ext_p & armed & ~(sleep_i & ~bypass_i);

   always_comb begin
      case (src_i)
         SRC_INSTR: tick_o = (q4 == 2'd3);
         SRC_SYS:   tick_o = 1'b1;
         SRC_EXT:   tick_o = ext_hit;
         default:   tick_o = 1'b0;
      endcase
   end

   // R4: an external edge is only counted once a falling edge has armed the path
   AST_EXT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      (src_i == SRC_EXT && !armed) |-> !tick_o); // R4
endmodule

// File: rtl/gtmr16_gate.sv
module gtmr16_gate
   import gtmr16_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  gate_sel_e sel_i,
   input  logic      pin_i,
   input  logic      match_i,
   input  logic      cmp1_i,
   input  logic      cmp2_i,
   input  logic      en_i,
   input  logic      inv_i,
   input  logic      tog_i,
   input  logic      sp_i,
   input  logic      go_i,
   output logic      gval_o,
   output logic      done_o
);
   logic g_mux, g_s, g_pol, gp_q, tg, g_t, gt_q, rise, armed;
   sp_state_e st, st_nx;

   always_comb begin
      case (sel_i)
         GSEL_PIN:   g_mux = pin_i;
         GSEL_MATCH: g_mux = match_i;
         GSEL_CMP1:  g_mux = cmp1_i;
         default:    g_mux = cmp2_i;
      endcase
   end

   gtmr16_sync #(.STAGES(SYNC_STAGES)) u_gsync (
      .clk(clk), .rst_n(rst_n), .d_i(g_mux), .q_o(g_s)
   );

   assign g_pol = g_s ^ inv_i;
   assign g_t   = tog_i ? tg : g_pol;
   assign rise  = g_t & ~gt_q;
   assign armed = en_i & sp_i & go_i;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         gp_q <= 1'b0;
         gt_q <= 1'b0;
         tg   <= 1'b0;
         st   <= SP_IDLE;
      end else begin
         gp_q <= g_pol;
         gt_q <= g_t;
         st   <= st_nx;
         if (!en_i || !tog_i)   tg <= 1'b0;
         else if (g_pol && !gp_q) tg <= ~tg;
      end

   always_comb begin
      st_nx = st;
      case (st)
         SP_IDLE:   if (armed) st_nx = SP_WAIT;
         SP_WAIT:   if (!armed) st_nx = SP_IDLE;
                    else if (rise) st_nx = SP_ACTIVE;
         SP_ACTIVE: if (!sp_i || !en_i || !g_t) st_nx = SP_IDLE;
         default:   st_nx = SP_IDLE;
      endcase
   end

   assign gval_o = sp_i ? (g_t & ((st == SP_ACTIVE) | ((st == SP_WAIT) & rise & armed)))
                        : g_t;
   assign done_o = (st == SP_ACTIVE) & ~g_t & sp_i & en_i;

   // R10: a single pulse window never opens unless the go bit armed it
   AST_SP_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_i && st == SP_IDLE) |-> !gval_o); // R10
endmodule

// File: rtl/gtmr16_count.sv
module gtmr16_count
   import gtmr16_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int CNT_BYTES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        run_i,
   input  logic                        step_i,
   input  logic [PSEL_W-1:0]           psel_i,
   input  logic [CNT_BYTES-1:0]        wr_lane_i,
   input  logic [BYTE_W-1:0]           wdata_i,
   output logic [BYTE_W*CNT_BYTES-1:0] cnt_o,
   output logic                        wrap_o
);
   localparam int CNT_W = BYTE_W * CNT_BYTES;

   logic [PRE_W-1:0] pre, pre_last;
   logic [CNT_W-1:0] cnt, cnt_inc, cnt_d;
   logic adv, inc;

   assign pre_last = (PRE_W'(1) << psel_i) - PRE_W'(1);
   assign adv      = run_i & step_i;
   assign inc      = adv & (pre == pre_last);
   assign cnt_inc  = cnt + CNT_W'(inc);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                      pre <= '0;
      else if (!run_i || wr_lane_i[0]) pre <= '0;
      else if (adv)                    pre <= (pre == pre_last) ? '0 : pre + PRE_W'(1);

   generate
      for (genvar b = 0; b < CNT_BYTES; b++) begin : g_lane
         assign cnt_d[b*BYTE_W +: BYTE_W] = wr_lane_i[b] ? wdata_i
                                                         : cnt_inc[b*BYTE_W +: BYTE_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_d;

   assign cnt_o  = cnt;
   assign wrap_o = inc & (&cnt) & ~(|wr_lane_i);

   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !(|wr_lane_i)) |=> $stable(cnt)); // R6

   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(|wr_lane_i) |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1))); // R3
endmodule

// File: rtl/gtmr16_top.sv
module gtmr16_top
   import gtmr16_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int CNT_BYTES   = 2,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_clk_i,
   input  logic              sosc_i,
   input  logic              sleep_i,
   input  logic              gate_pin_i,
   input  logic              nbr_match_i,
   input  logic              cmp1_i,
   input  logic              cmp2_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic              reg_we_i,
   input  logic [BYTE_W-1:0] reg_wdata_i,
   output logic [BYTE_W-1:0] reg_rdata_o,
   output logic              ovf_flag_o,
   output logic              gate_flag_o
);
   localparam int CNT_W  = BYTE_W * CNT_BYTES;
   localparam int A_CTRL = CNT_BYTES;
   localparam int A_GATE = CNT_BYTES + 1;
   localparam int A_FLAG = CNT_BYTES + 2;

   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("gtmr16_top: register fields need BYTE_W of 8");
      end
      if (CNT_BYTES < 1 || CNT_BYTES > 4) begin : g_bad_bytes
         $error("gtmr16_top: CNT_BYTES must be 1..4");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("gtmr16_top: SYNC_STAGES must be 1..4");
      end
      if (CNT_BYTES + 3 > (1 << ADDR_W)) begin : g_bad_addr
         $error("gtmr16_top: ADDR_W too small for the register map");
      end
   endgenerate

   // control register fields
   logic              run_q, byp_q, osc_q;
   logic [1:0]        src_q;
   logic [PSEL_W-1:0] psel_q;
   // gate register fields
   logic       gen_q, ginv_q, gtog_q, gsp_q, go_q;
   logic [1:0] gsel_q;
   // flags
   logic ovf_q, gflag_q;

   logic [CNT_BYTES-1:0] wr_lane;
   logic [CNT_W-1:0]     cnt;
   logic wr_ctrl, wr_gate, wr_flag;
   logic tick, gval, sp_done, allow, wrap;

   generate
      for (genvar b = 0; b < CNT_BYTES; b++) begin : g_wdec
         assign wr_lane[b] = reg_we_i && (reg_addr_i == ADDR_W'(b));
      end
   endgenerate

   assign wr_ctrl = reg_we_i && (reg_addr_i == ADDR_W'(A_CTRL));
   assign wr_gate = reg_we_i && (reg_addr_i == ADDR_W'(A_GATE));
   assign wr_flag = reg_we_i && (reg_addr_i == ADDR_W'(A_FLAG));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         run_q <= 1'b0; src_q <= '0; psel_q <= '0; byp_q <= 1'b0; osc_q <= 1'b0;
         gen_q <= 1'b0; ginv_q <= 1'b0; gtog_q <= 1'b0; gsp_q <= 1'b0; gsel_q <= '0;
         go_q <= 1'b0; ovf_q <= 1'b0; gflag_q <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            run_q  <= reg_wdata_i[0];
            src_q  <= reg_wdata_i[2:1];
            psel_q <= reg_wdata_i[4:3];
            byp_q  <= reg_wdata_i[5];
            osc_q  <= reg_wdata_i[6];
         end
         if (wr_gate) begin
            gen_q  <= reg_wdata_i[0];
            ginv_q <= reg_wdata_i[1];
            gtog_q <= reg_wdata_i[2];
            gsp_q  <= reg_wdata_i[3];
            gsel_q <= reg_wdata_i[7:6];
         end
         if (sp_done)      go_q <= 1'b0;
         else if (wr_gate) go_q <= reg_wdata_i[4];
         if (wrap)                             ovf_q <= 1'b1;
         else if (wr_flag && !reg_wdata_i[0])  ovf_q <= 1'b0;
         if (sp_done)                          gflag_q <= 1'b1;
         else if (wr_flag && !reg_wdata_i[1])  gflag_q <= 1'b0;
      end

   gtmr16_clk_sel #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
      .clk(clk), .rst_n(rst_n), .run_i(run_q), .src_i(cnt_src_e'(src_q)),
      .bypass_i(byp_q), .osc_sel_i(osc_q), .ext_clk_i(ext_clk_i), .sosc_i(sosc_i),
      .sleep_i(sleep_i), .tick_o(tick)
   );

   gtmr16_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk(clk), .rst_n(rst_n), .sel_i(gate_sel_e'(gsel_q)), .pin_i(gate_pin_i),
      .match_i(nbr_match_i), .cmp1_i(cmp1_i), .cmp2_i(cmp2_i), .en_i(gen_q),
      .inv_i(ginv_q), .tog_i(gtog_q), .sp_i(gsp_q), .go_i(go_q),
      .gval_o(gval), .done_o(sp_done)
   );

   assign allow = ~gen_q | gval;

   gtmr16_count #(.BYTE_W(BYTE_W), .CNT_BYTES(CNT_BYTES)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run_i(run_q), .step_i(tick & allow),
      .psel_i(psel_q), .wr_lane_i(wr_lane), .wdata_i(reg_wdata_i),
      .cnt_o(cnt), .wrap_o(wrap)
   );

   always_comb begin
      reg_rdata_o = '0;
      if (int'(reg_addr_i) < CNT_BYTES)
         reg_rdata_o = BYTE_W'(cnt >> (BYTE_W * int'(reg_addr_i)));
      else if (int'(reg_addr_i) == A_CTRL)
         reg_rdata_o = {1'b0, osc_q, byp_q, psel_q, src_q, run_q};
      else if (int'(reg_addr_i) == A_GATE)
         reg_rdata_o = {gsel_q, gval, go_q, gsp_q, gtog_q, ginv_q, gen_q};
      else if (int'(reg_addr_i) == A_FLAG)
         reg_rdata_o = {6'b0, gflag_q, ovf_q};
   end

   assign ovf_flag_o  = ovf_q;
   assign gate_flag_o = gflag_q;

   AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> ovf_q); // R7

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !wr_flag) |=> ovf_q); // R7

   AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_q && !gval && !(|wr_lane)) |=> $stable(cnt)); // R8

   AST_SP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      sp_done |=> (!go_q && gflag_q)); // R10
endmodule

// File: tb/sim_gtmr16_top.sv
`timescale 1ns/1ps
module sim_gtmr16_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep = 1'b0, gpin = 1'b0, gmatch = 1'b0, gc1 = 1'b0, gc2 = 1'b0;
   logic [2:0] addr = '0;
   logic       we = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic ovf_o, gflag_o;
   logic wave = 1'b0, man_lvl = 1'b0;
   int   ext_mode = 0;   // 0 manual level on pin, 1 wave on pin, 2 wave on oscillator
   logic ext_clk, sosc;
   int   n_run = 0, n_fail = 0;
   bit   finished = 1'b0;

   assign ext_clk = (ext_mode == 0) ? man_lvl : ((ext_mode == 1) ? wave : 1'b0);
   assign sosc    = (ext_mode == 2) ? wave : 1'b0;

   always #2.5 clk = ~clk;

   gtmr16_top u0 (
      .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .sosc_i(sosc), .sleep_i(sleep),
      .gate_pin_i(gpin), .nbr_match_i(gmatch), .cmp1_i(gc1), .cmp2_i(gc2),
      .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .ovf_flag_o(ovf_o), .gate_flag_o(gflag_o)
   );

   // external wave: period of 4 system clocks
   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         ph++;
         if (ph == 2) begin ph = 0; wave = ~wave; end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      addr = 3'(a); wdata = 8'(d); we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      addr = 3'(a);
      #1;
      v = int'(rdata);
   endtask

   function automatic int ctl(int run, int src, int ps, int byp, int osc);
      return run | (src << 1) | (ps << 3) | (byp << 5) | (osc << 6);
   endfunction

   task automatic stop_clear();
      wr(2, 0); wr(1, 0); wr(0, 0);
   endtask

   task automatic window(input int warm, input int m, output int delta);
      int a, b;
      repeat (warm) @(negedge clk);
      rd(0, a);
      repeat (m) @(negedge clk);
      rd(0, b);
      delta = (b - a) & 8'hFF;
   endtask

   task automatic set_gsrc(input int src, input logic lvl);
      gpin   = (src == 0) ? lvl : ~lvl;
      gmatch = (src == 1) ? lvl : ~lvl;
      gc1    = (src == 2) ? lvl : ~lvl;
      gc2    = (src == 3) ? lvl : ~lvl;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_fail++; n_run++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int v, d, a0, exp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state of the whole register map
      for (int r = 0; r < 5; r++) begin
         rd(r, v);
         chk(v == 0, $sformatf("R1 reg%0d after reset", r), v, 0);
      end

      // R2 / R3: internal sources swept over every prescale code
      for (int cs = 0; cs < 4; cs++) begin
         if (cs == 2) continue;
         for (int ps = 0; ps < 4; ps++) begin
            stop_clear();
            wr(2, ctl(1, cs, ps, 0, 0));
            window(8, 128, d);
            exp = (cs == 0) ? (32 >> ps) : ((cs == 1) ? (128 >> ps) : 0);
            chk(d == exp, $sformatf("R2 R3 src=%0d ps=%0d", cs, ps), d, exp);
         end
      end

      // R6: run cleared holds the counter
      stop_clear();
      wr(2, ctl(1, 1, 0, 0, 0));
      repeat (5) @(negedge clk);
      wr(2, ctl(0, 1, 0, 0, 0));
      window(2, 40, d);
      chk(d == 0, "R6 hold with run=0", d, 0);

      // R4 / R5: external pin and oscillator, synchronized and bypassed
      for (int osc = 0; osc < 2; osc++)
         for (int byp = 0; byp < 2; byp++)
            for (int ps = 0; ps < 4; ps++) begin
               ext_mode = osc ? 2 : 1;
               stop_clear();
               wr(2, ctl(1, 2, ps, byp, osc));
               window(16, 128, d);
               exp = 32 >> ps;
               chk(d == exp, $sformatf("R4 R5 osc=%0d byp=%0d ps=%0d", osc, byp, ps), d, exp);
            end

      // R4: oscillator selected while only the pin toggles
      ext_mode = 1;
      stop_clear();
      wr(2, ctl(1, 2, 0, 0, 1));
      window(16, 64, d);
      chk(d == 0, "R4 oscillator selected, pin toggling", d, 0);

      // R5: sleep stops the synchronized path only
      sleep = 1'b1;
      stop_clear();
      wr(2, ctl(1, 2, 0, 0, 0));
      window(16, 128, d);
      chk(d == 0, "R5 sleep synchronized", d, 0);
      stop_clear();
      wr(2, ctl(1, 2, 0, 1, 0));
      window(16, 128, d);
      chk(d == 32, "R5 sleep bypassed", d, 32);
      sleep = 1'b0;

      // R4: first rising edge after enable needs a prior falling edge
      ext_mode = 0; man_lvl = 1'b0;
      stop_clear();
      repeat (6) @(negedge clk);
      wr(2, ctl(1, 2, 0, 0, 0));
      repeat (4) @(negedge clk);
      man_lvl = 1'b1;
      repeat (6) @(negedge clk);
      rd(0, v);
      chk(v == 0, "R4 rise without prior fall", v, 0);
      man_lvl = 1'b0;
      repeat (6) @(negedge clk);
      man_lvl = 1'b1;
      repeat (6) @(negedge clk);
      rd(0, v);
      chk(v == 1, "R4 rise after fall", v, 1);
      ext_mode = 1;

      // R11: low-byte write restarts the prescaler (code 3, divide by 8)
      stop_clear();
      wr(2, ctl(1, 1, 3, 0, 0));
      repeat (13) @(negedge clk);
      wr(0, 0);
      repeat (7) @(negedge clk);
      rd(0, v);
      chk(v == 0, "R11 seven cycles after low write", v, 0);
      @(negedge clk);
      rd(0, v);
      chk(v == 1, "R11 eighth cycle after low write", v, 1);
      wr(2, 0);
      wr(1, 8'h5A);
      rd(1, v);
      chk(v == 8'h5A, "R11 high byte load", v, 8'h5A);

      // R7: rollover sets a sticky flag
      stop_clear();
      wr(1, 8'hFF); wr(0, 8'hFE);
      rd(4, v);
      chk(v == 0, "R7 flag clear before wrap", v, 0);
      wr(2, ctl(1, 1, 0, 0, 0));
      repeat (4) @(negedge clk);
      wr(2, 0);
      rd(1, v);
      chk(v == 0, "R7 high byte wrapped", v, 0);
      rd(0, v);
      chk(v > 0 && v < 16, "R7 low byte after wrap", v, 4);
      rd(4, v);
      chk(v == 1, "R7 flag after wrap", v, 1);
      wr(4, 8'h03);
      rd(4, v);
      chk(v == 1, "R7 writing 1 keeps flag", v, 1);
      chk(ovf_o == 1'b1, "R7 flag output", int'(ovf_o), 1);
      wr(4, 8'h00);
      rd(4, v);
      chk(v == 0, "R7 writing 0 clears flag", v, 0);

      // R8: every gate source, both polarities, both levels
      for (int src = 0; src < 4; src++)
         for (int pol = 0; pol < 2; pol++)
            for (int lvl = 0; lvl < 2; lvl++) begin
               set_gsrc(src, 1'(lvl));
               stop_clear();
               wr(3, (src << 6) | (pol << 1) | 1);
               wr(2, ctl(1, 1, 0, 0, 0));
               repeat (8) @(negedge clk);
               rd(3, v);
               exp = lvl ^ pol;
               chk(((v >> 5) & 1) == exp, $sformatf("R8 gate value src=%0d pol=%0d lvl=%0d", src, pol, lvl), (v >> 5) & 1, exp);
               window(0, 32, d);
               chk(d == exp * 32, $sformatf("R8 gated count src=%0d pol=%0d lvl=%0d", src, pol, lvl), d, exp * 32);
            end
      set_gsrc(0, 1'b0);

      // R10: single pulse acquisition
      stop_clear();
      wr(4, 0);
      wr(2, ctl(1, 1, 0, 0, 0));
      wr(3, 8'h19);
      window(4, 20, d);
      chk(d == 0, "R10 armed, no pulse yet", d, 0);
      rd(0, a0);
      gpin = 1'b1;
      repeat (10) @(negedge clk);
      gpin = 1'b0;
      repeat (10) @(negedge clk);
      rd(0, v);
      chk(v == ((a0 + 10) & 8'hFF), "R10 counts one pulse", v, (a0 + 10) & 8'hFF);
      rd(3, d);
      chk(((d >> 4) & 1) == 0, "R10 go cleared", (d >> 4) & 1, 0);
      rd(4, d);
      chk(d == 2, "R10 gate flag set", d, 2);
      chk(gflag_o == 1'b1, "R10 gate flag output", int'(gflag_o), 1);
      @(negedge clk);
      gpin = 1'b1;
      repeat (5) @(negedge clk);
      gpin = 1'b0;
      repeat (10) @(negedge clk);
      rd(0, d);
      chk(d == v, "R10 second pulse ignored", d, v);
      wr(4, 8'h01);
      rd(4, d);
      chk(d == 0, "R10 gate flag cleared by 0", d, 0);

      // R9: toggle mode spans a full gate period
      stop_clear();
      wr(3, 8'h05);
      wr(2, ctl(1, 1, 0, 0, 0));
      window(8, 32, d);
      chk(d == 0, "R9 toggle starts closed", d, 0);
      gpin = 1'b1; repeat (3) @(negedge clk); gpin = 1'b0;
      window(8, 32, d);
      chk(d == 32, "R9 open after one rising edge", d, 32);
      gpin = 1'b1; repeat (3) @(negedge clk); gpin = 1'b0;
      window(8, 32, d);
      chk(d == 0, "R9 closed after second rising edge", d, 0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule